// File: doc/BRIEF.md
# Multi-Personality Program Window Mapper

This block turns a CPU fetch address in the upper half of the CPU space (0x8000 to 0xFFFF) into a physical program-memory address for a cartridge that holds many games. Three outer configuration bytes pick a banking personality and confine it to one region of the program ROM. The inner bank registers of each personality come in as plain inputs from elsewhere. There are four personalities: a fixed flat window, two four-slot 8 KiB schemes that differ only in which registers feed them and which bit swaps their slots, and a two-slot 16 KiB scheme with an optional 32 KiB form.

Every bank number passes through an outer AND/OR step. The inner value supplies the bits under a region mask, and an outer offset supplies the bits above it. A chip-select output picks between plain program ROM and an extended space in which the graphics ROM follows directly after the last program ROM byte. This lets CPU fetches read graphics data. The address, the chip-select and a window-valid flag are registered and appear one clock after the CPU address is presented.

Top module: `prg_window_mapper`

## Requirements
- R1: All outputs are registered. The values for the inputs present at a clock edge appear after that edge. A synchronous active-high reset clears prg_addr, prg_chip and prg_valid to 0.
- R2: prg_valid equals bit 15 of the CPU address. Addresses below 0x8000 give prg_valid = 0.
- R3: The region mask is 0x0F when cfg_c bit 2 is 1 and 0x1F when it is 0. The region offset is cfg_b shifted right by one. An 8 KiB bank is (inner AND mask) OR (offset AND NOT mask).
- R4: When cfg_c bit 4 is 1, the flat personality is used. If cfg_c bit 2 is 1, the 16 KiB bank offset>>1 appears at both 0x8000 and 0xC000. Otherwise the 32 KiB bank offset>>2 covers the whole window.
- R5: When cfg_c bit 4 is 0 and cfg_a bit 1 is 0, the indexed four-slot personality is used. The 8 KiB slots at 0x8000, 0xA000, 0xC000 and 0xE000 hold idx_bank_lo, idx_bank_hi, 0xFE and 0xFF, each after R3. When idx_select bit 6 is 1, the contents of the 0x8000 and 0xC000 slots swap.
- R6: When cfg_c bit 4 is 0 and cfg_a bits 1 and 0 are both 1, the alternate four-slot personality is used. It has the same layout as R5, with alt_bank_lo and alt_bank_hi, and alt_ctrl bit 1 does the swap.
- R7: When cfg_c bit 4 is 0, cfg_a bit 1 is 1 and cfg_a bit 0 is 0, the split personality is used. Its mask and offset are the R3 values shifted right by one, in 16 KiB units. With split_ctrl bit 3 = 1 and bit 2 = 1, split_bank sits at 0x8000 and 0xFF sits at 0xC000. With bit 3 = 1 and bit 2 = 0, 0x00 sits at 0x8000 and split_bank sits at 0xC000.
- R8: In the split personality with split_ctrl bit 3 = 0, the 32 KiB bank is the masked split_bank value shifted right by one. prg_chip is then 0 whatever cfg_c bit 0 holds.
- R9: In every other case, prg_chip is 1 exactly when cfg_c bit 0 is 1 and gfx_ram_present is 1.
- R10: prg_addr is the 8 KiB bank number followed by CPU address bits 12..0. For a 16 KiB bank, CPU bit 13 is the lowest bank bit. For a 32 KiB bank, CPU bits 14..13 are the two lowest bank bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU fetch address |
| cfg_a | input | 8 | Outer byte A: personality select bits |
| cfg_b | input | 8 | Outer byte B: region offset source |
| cfg_c | input | 8 | Outer byte C: flat, mask size, extended-space bits |
| idx_select | input | 8 | Index register of the indexed four-slot personality |
| idx_bank_lo | input | 8 | Indexed personality, switchable first bank |
| idx_bank_hi | input | 8 | Indexed personality, 0xA000 bank |
| alt_ctrl | input | 8 | Alternate personality control (bit 1 swaps) |
| alt_bank_lo | input | 8 | Alternate personality, switchable first bank |
| alt_bank_hi | input | 8 | Alternate personality, 0xA000 bank |
| split_ctrl | input | 8 | Split personality control (bits 3 and 2) |
| split_bank | input | 8 | Split personality bank value |
| gfx_ram_present | input | 1 | Graphics RAM fitted; enables the extended space |
| prg_addr | output | 21 | Physical program address (8 KiB bank and byte offset) |
| prg_chip | output | 1 | 1 selects the extended program-plus-graphics space |
| prg_valid | output | 1 | CPU address lies in the 0x8000-0xFFFF window |

## Verification
The hardest case to reach is a conflict between selections. The split 32 KiB form must keep prg_chip low even when the extended space is requested and graphics RAM is present. The mask and offset also change which bits a swapped slot takes from each source. The bench reaches these cases by sweeping every combination of the decoding bits of cfg_a and cfg_c, both swap bits, both split control bits and both states of gfx_ram_present. It does this against several offset bytes and every 8 KiB slot of the window, so each override meets every personality and layout. The expected address is worked out arithmetically for each point.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    parameter int BANK_W  = 8;
    parameter int PAGE_W  = 13;
    parameter int CPU_AW  = 16;
    parameter int WIDE_MASK_BITS = 5;
    localparam int ADDR_W = BANK_W + PAGE_W;

    typedef enum logic [1:0] {
        PM_FLAT  = 2'd0,
        PM_QIDX  = 2'd1,
        PM_QALT  = 2'd2,
        PM_SPLIT = 2'd3
    } pmode_e;

    typedef struct packed {
        pmode_e             mode;
        logic [BANK_W-1:0]  mask;
        logic [BANK_W-1:0]  offs;
        logic               narrow;
        logic               ext_req;
    } region_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank8;
        logic              chip;
    } bank_sel_t;

    function automatic logic [BANK_W-1:0] merge_bank(
        input logic [BANK_W-1:0] inner,
        input logic [BANK_W-1:0] mask,
        input logic [BANK_W-1:0] offs);
        return (inner & mask) | (offs & ~mask);
    endfunction

    function automatic logic [BANK_W-1:0] ones_mask(input int bits);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++) m[i] = (i < bits);
        return m;
    endfunction

endpackage

// File: rtl/prg_mode_decode.sv
module prg_mode_decode
    import prg_map_pkg::*;
(
    input  logic [BANK_W-1:0] cfg_a,
    input  logic [BANK_W-1:0] cfg_b,
    input  logic [BANK_W-1:0] cfg_c,
    output region_t           region
);
    localparam logic [BANK_W-1:0] WIDE_M   = ones_mask(WIDE_MASK_BITS);
    localparam logic [BANK_W-1:0] NARROW_M = ones_mask(WIDE_MASK_BITS - 1);

    always_comb begin
        region.narrow  = cfg_c[2];
        region.ext_req = cfg_c[0];
        region.mask    = cfg_c[2] ? NARROW_M : WIDE_M;
        region.offs    = cfg_b >> 1;
        if (cfg_c[4])
            region.mode = PM_FLAT;
        else if (!cfg_a[1])
            region.mode = PM_QIDX;
        else if (cfg_a[0])
            region.mode = PM_QALT;
        else
            region.mode = PM_SPLIT;
    end
endmodule

// File: rtl/prg_quad_bank.sv
module prg_quad_bank
    import prg_map_pkg::*;
(
    input  logic [1:0]        slot,
    input  logic              swap,
    input  logic [BANK_W-1:0] bank_lo,
    input  logic [BANK_W-1:0] bank_hi,
    input  logic [BANK_W-1:0] mask,
    input  logic [BANK_W-1:0] offs,
    output logic [BANK_W-1:0] bank8
);
    localparam logic [BANK_W-1:0] LAST   = '1;
    localparam logic [BANK_W-1:0] SECOND = {{(BANK_W-1){1'b1}}, 1'b0};

    logic [BANK_W-1:0] inner;

    always_comb begin
        unique case (slot)
            2'd0:    inner = swap ? SECOND : bank_lo;
            2'd1:    inner = bank_hi;
            2'd2:    inner = swap ? bank_lo : SECOND;
            default: inner = LAST;
        endcase
        bank8 = merge_bank(inner, mask, offs);
    end
endmodule

// File: rtl/prg_split_bank.sv
module prg_split_bank
    import prg_map_pkg::*;
(
    input  logic [1:0]        hi_bits,
    input  logic [BANK_W-1:0] ctrl,
    input  logic [BANK_W-1:0] bank,
    input  logic [BANK_W-1:0] mask,
    input  logic [BANK_W-1:0] offs,
    output logic [BANK_W-1:0] bank8,
    output logic              whole32
);
    logic [BANK_W-1:0] m16, o16, inner, b16, b32;

    always_comb begin
        m16     = mask >> 1;
        o16     = offs >> 1;
        whole32 = !ctrl[3];
        if (ctrl[2])
            inner = hi_bits[1] ? '1 : bank;
        else
            inner = hi_bits[1] ? bank : '0;
        b16 = merge_bank(inner, m16, o16);
        b32 = merge_bank(bank, m16, o16) >> 1;
        if (whole32)
            bank8 = {b32[BANK_W-3:0], hi_bits};
        else
            bank8 = {b16[BANK_W-2:0], hi_bits[0]};
    end
endmodule

// File: rtl/prg_window_mapper.sv
module prg_window_mapper
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cfg_a,
    input  logic [7:0]        cfg_b,
    input  logic [7:0]        cfg_c,
    input  logic [7:0]        idx_select,
    input  logic [7:0]        idx_bank_lo,
    input  logic [7:0]        idx_bank_hi,
    input  logic [7:0]        alt_ctrl,
    input  logic [7:0]        alt_bank_lo,
    input  logic [7:0]        alt_bank_hi,
    input  logic [7:0]        split_ctrl,
    input  logic [7:0]        split_bank,
    input  logic              gfx_ram_present,
    output logic [20:0]       prg_addr,
    output logic              prg_chip,
    output logic              prg_valid
);
    region_t           region;
    logic [1:0]        slot;
    logic [BANK_W-1:0] quad_lo, quad_hi, quad_bank, split_b8, flat_b8;
    logic              quad_swap, split_whole;
    bank_sel_t         sel;

    assign slot = cpu_addr[PAGE_W+1:PAGE_W];

    prg_mode_decode u_decode (
        .cfg_a  (cfg_a),
        .cfg_b  (cfg_b),
        .cfg_c  (cfg_c),
        .region (region)
    );

    always_comb begin
        if (region.mode == PM_QALT) begin
            quad_lo   = alt_bank_lo;
            quad_hi   = alt_bank_hi;
            quad_swap = alt_ctrl[1];
        end else begin
            quad_lo   = idx_bank_lo;
            quad_hi   = idx_bank_hi;
            quad_swap = idx_select[6];
        end
    end

    prg_quad_bank u_quad (
        .slot    (slot),
        .swap    (quad_swap),
        .bank_lo (quad_lo),
        .bank_hi (quad_hi),
        .mask    (region.mask),
        .offs    (region.offs),
        .bank8   (quad_bank)
    );

    prg_split_bank u_split (
        .hi_bits (slot),
        .ctrl    (split_ctrl),
        .bank    (split_bank),
        .mask    (region.mask),
        .offs    (region.offs),
        .bank8   (split_b8),
        .whole32 (split_whole)
    );

    always_comb begin
        logic [BANK_W-1:0] f16, f32;
        f16 = region.offs >> 1;
        f32 = region.offs >> 2;
        if (region.narrow)
            flat_b8 = {f16[BANK_W-2:0], slot[0]};
        else
            flat_b8 = {f32[BANK_W-3:0], slot};
    end

    always_comb begin
        sel.chip = region.ext_req && gfx_ram_present;
        unique case (region.mode)
            PM_FLAT:  sel.bank8 = flat_b8;
            PM_SPLIT: begin
                sel.bank8 = split_b8;
                if (split_whole) sel.chip = 1'b0;
            end
            default:  sel.bank8 = quad_bank;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prg_addr  <= '0;
            prg_chip  <= 1'b0;
            prg_valid <= 1'b0;
        end else begin
            prg_addr  <= {sel.bank8, cpu_addr[PAGE_W-1:0]};
            prg_chip  <= sel.chip;
            prg_valid <= cpu_addr[CPU_AW-1];
        end
    end
endmodule

// File: rtl/prg_window_mapper_chk.sv
module prg_window_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cfg_a,
    input logic [7:0]  cfg_c,
    input logic [7:0]  split_ctrl,
    input logic        gfx_ram_present,
    input logic [20:0] prg_addr,
    input logic        prg_chip,
    input logic        prg_valid
);
    logic seen;
    always_ff @(posedge clk) seen <= !rst;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!prg_valid && !prg_chip && prg_addr == '0));

    p_valid_track_r2: assert property (@(posedge clk) disable iff (rst)
        seen |-> prg_valid == $past(cpu_addr[15]));

    p_offset_pass_r10: assert property (@(posedge clk) disable iff (rst)
        seen |-> prg_addr[12:0] == $past(cpu_addr[12:0]));

    p_flat32_low_r4: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(cfg_c[4] && !cfg_c[2])) |-> prg_addr[14:13] == $past(cpu_addr[14:13]));

    p_whole32_plain_r8: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(!cfg_c[4] && cfg_a[1] && !cfg_a[0] && !split_ctrl[3])) |-> !prg_chip);

    p_chip_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(!cfg_c[0] || !gfx_ram_present)) |-> !prg_chip);
endmodule

bind prg_window_mapper prg_window_mapper_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cpu_addr        (cpu_addr),
    .cfg_a           (cfg_a),
    .cfg_c           (cfg_c),
    .split_ctrl      (split_ctrl),
    .gfx_ram_present (gfx_ram_present),
    .prg_addr        (prg_addr),
    .prg_chip        (prg_chip),
    .prg_valid       (prg_valid)
);

// File: tb/prg_window_mapper_bench.sv
module prg_window_mapper_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cfg_a = '0, cfg_b = '0, cfg_c = '0;
    logic [7:0]  idx_select = '0, idx_bank_lo = '0, idx_bank_hi = '0;
    logic [7:0]  alt_ctrl = '0, alt_bank_lo = '0, alt_bank_hi = '0;
    logic [7:0]  split_ctrl = '0, split_bank = '0;
    logic        gfx_ram_present = 1'b0;
    logic [20:0] prg_addr;
    logic        prg_chip, prg_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    prg_window_mapper u_prg_window_mapper (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
        .idx_select(idx_select), .idx_bank_lo(idx_bank_lo), .idx_bank_hi(idx_bank_hi),
        .alt_ctrl(alt_ctrl), .alt_bank_lo(alt_bank_lo), .alt_bank_hi(alt_bank_hi),
        .split_ctrl(split_ctrl), .split_bank(split_bank),
        .gfx_ram_present(gfx_ram_present),
        .prg_addr(prg_addr), .prg_chip(prg_chip), .prg_valid(prg_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (addr=%h a=%h b=%h c=%h sc=%h)",
                     tag, act, exp, cpu_addr, cfg_a, cfg_b, cfg_c, split_ctrl);
        end
    endtask

    function automatic logic [7:0] mix(input logic [7:0] v, input logic [7:0] m, input logic [7:0] o);
        return (v & m) | (o & ~m);
    endfunction

    // Expected 8 KiB bank number, computed from the requirements
    function automatic logic [7:0] exp_bank8();
        logic [7:0] m, o, v, b;
        logic [1:0] s;
        bit sw;
        s = cpu_addr[14:13];
        m = cfg_c[2] ? 8'h0F : 8'h1F;            // R3
        o = cfg_b >> 1;
        if (cfg_c[4]) begin                       // R4
            if (cfg_c[2]) begin b = o >> 1; return (b << 1) | 8'(s[0]); end
            b = o >> 2; return (b << 2) | 8'(s);
        end
        if (!cfg_a[1] || cfg_a[0]) begin          // R5 / R6
            sw = !cfg_a[1] ? idx_select[6] : alt_ctrl[1];
            case (s)
                2'd0: v = sw ? 8'hFE : (!cfg_a[1] ? idx_bank_lo : alt_bank_lo);
                2'd1: v = !cfg_a[1] ? idx_bank_hi : alt_bank_hi;
                2'd2: v = sw ? (!cfg_a[1] ? idx_bank_lo : alt_bank_lo) : 8'hFE;
                default: v = 8'hFF;
            endcase
            return mix(v, m, o);
        end
        if (split_ctrl[3]) begin                  // R7
            if (split_ctrl[2]) v = s[1] ? 8'hFF : split_bank;
            else               v = s[1] ? split_bank : 8'h00;
            b = mix(v, m >> 1, o >> 1);
            return (b << 1) | 8'(s[0]);
        end
        b = mix(split_bank, m >> 1, o >> 1) >> 1; // R8
        return (b << 2) | 8'(s);
    endfunction

    function automatic string mode_tag();
        if (cfg_c[4]) return "R4";
        if (!cfg_a[1]) return "R5";
        if (cfg_a[0]) return "R6";
        if (split_ctrl[3]) return "R7";
        return "R8";
    endfunction

    task automatic step_and_check();
        logic [20:0] ea;
        logic        ec;
        string       t;
        ea = {exp_bank8(), cpu_addr[12:0]};
        ec = cfg_c[0] && gfx_ram_present && !(!cfg_c[4] && cfg_a[1] && !cfg_a[0] && !split_ctrl[3]);
        t  = mode_tag();
        @(posedge clk);
        @(negedge clk);
        check("R2 valid", 32'(prg_valid), 32'(cpu_addr[15]));
        if (cpu_addr[15]) begin
            check({t, " R3 addr"}, 32'(prg_addr), 32'(ea));
            check("R10 low", 32'(prg_addr[12:0]), 32'(cpu_addr[12:0]));
            check((t == "R8") ? "R8 chip" : "R9 chip", 32'(prg_chip), 32'(ec));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b_vals [4] = '{8'h00, 8'h5A, 8'hFF, 8'h3C};
        repeat (3) @(posedge clk);
        @(negedge clk);
        cpu_addr = 16'hFFFF; cfg_c = 8'h01; gfx_ram_present = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 reset valid", 32'(prg_valid), 0);
        check("R1 reset chip", 32'(prg_chip), 0);
        check("R1 reset addr", 32'(prg_addr), 0);
        rst = 1'b0;
        check("R1 no change before edge", 32'(prg_valid), 0);

        idx_bank_lo = 8'h13; idx_bank_hi = 8'h2B;
        alt_bank_lo = 8'h35; alt_bank_hi = 8'h0E;
        split_bank  = 8'h19;

        for (int bi = 0; bi < 4; bi++)
        for (int c2 = 0; c2 < 8; c2++)
        for (int c0 = 0; c0 < 4; c0++)
        for (int sc = 0; sc < 4; sc++)
        for (int sw = 0; sw < 2; sw++)
        for (int rp = 0; rp < 2; rp++)
        for (int sl = 0; sl < 4; sl++) begin
            cfg_b = b_vals[bi];
            cfg_c = {3'b010, c2[2], 1'b0, c2[1], 1'b1, c2[0]};
            cfg_a = {6'b101000, c0[1:0]};
            split_ctrl = {4'b0000, sc[1:0], 2'b01};
            idx_select = {1'b0, sw[0], 6'h05};
            alt_ctrl   = {6'h00, sw[0], 1'b0};
            gfx_ram_present = rp[0];
            cpu_addr = {1'b1, sl[1:0], 13'(bi * 16'h0713 + sl * 16'h0101)};
            step_and_check();
        end

        for (int k = 0; k < 8; k++) begin
            cpu_addr = 16'(k * 16'h0F01);     // below the window
            cfg_c = 8'h11;
            step_and_check();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule